// File: doc/BRIEF.md
# PECI Bit-Timing Tick Divider

This block turns a fast reference clock into a slow, single-cycle enable pulse that paces the bit timing of a PECI bus engine. Three counters are chained. The first divides by a fixed four. The second divides by (4·M + 1), where M is an 8-bit timing code. The third divides by 2^E, where E is a 3-bit exponent. One pulse therefore comes out every 4·(4·M + 1)·2^E reference cycles. Software chooses M and E for an output rate between roughly 2 kHz and 2 MHz, with 1 MHz being typical. Working out those values is not part of this block.

Two copies of the timing code arrive on separate inputs, one for message timing and one for address timing. The divider counts only when the enable input is high, both codes are equal and the code is not zero. A registered flag reports whether that condition held at the previous edge. While the condition is false, every stage counter is cleared. The next valid period therefore starts from zero. New M or E values are taken up only at the end of a full period, so a running period is never cut short. A wrapping counter of emitted pulses lets a consumer or a bench measure the rate.

Top module: `peci_tick_div`

## Requirements
- R1: While reset is asserted, and after it is released with the enable input low, tick, rate_ok and tick_count are all zero.
- R2: With a valid setting applied from the first enabled edge, the first tick appears N cycles after the enable is raised, where N = 4·(4·M + 1)·2^E. Consecutive ticks are also N cycles apart. For example, M=1 and E=0 give 20, M=255 and E=0 give 4084, and M=1 and E=7 give 2560.
- R3: Each tick is high for exactly one reference cycle.
- R4: rate_ok is 1 in the cycle after an edge at which div_en=1, msg_tm equals adr_tm and msg_tm is nonzero. In every other case it is 0.
- R5: When msg_tm differs from adr_tm, or both are zero, no tick is produced and tick_count does not change, even with div_en high.
- R6: Dropping div_en stops ticks at once and clears all stages. After re-enabling, the first tick again takes a full N cycles.
- R7: A change to M or E in the middle of a period does not alter that period. The period after the next tick uses the new values.
- R8: tick_count rises by one for every tick, holds otherwise, and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_en | input | 1 | Divider run control |
| msg_tm | input | M_W (8) | Message timing code M |
| adr_tm | input | M_W (8) | Address timing code; must equal msg_tm |
| exp_sel | input | E_W (3) | Power-of-two exponent E |
| tick | output | 1 | One-cycle pulse per full division period |
| rate_ok | output | 1 | Registered flag that the divider is running with a valid setting |
| tick_count | output | CNT_W (16) | Wrapping count of emitted ticks |

## Verification
The hardest case to reach is a setting change that lands in the middle of a period. It takes effect only at the terminal count of all three stages. The stimulus holds M=1, E=0 for five cycles and then rewrites both timing codes and the exponent together. It then expects the old 20-cycle period to finish before a 72-cycle period follows. The bench also uses a 4-bit tick counter so that the wrap can be reached quickly. It covers both ends of the M and E ranges, and at the large end it uses M=255 with E=2 so that each period stays within the run length.

// File: rtl/peci_div_pkg.sv
package peci_div_pkg;

    // fixed first-stage ratio
    localparam int unsigned PRESCALE = 4;
    // second-stage step: ratio is STEP*M + 1
    localparam int unsigned STEP     = 4;

    // shortest possible period (M = 1, E = 0)
    localparam int unsigned MIN_PERIOD = PRESCALE * (STEP + 1);

endpackage

// File: rtl/pdiv_stage.sv
// Modulo counter stage: advances on adv, wraps after reaching lim,
// emits carry in the cycle it wraps. clr forces zero.
module pdiv_stage #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] lim,
    output logic         carry
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        carry = adv && (s_q.cnt >= lim);
        if (clr) begin
            s_d.cnt = '0;
        end else if (adv) begin
            s_d.cnt = carry ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pdiv_cfg.sv
// Holds the active timing code and exponent. Loads new values while idle
// and at each terminal count, so a running period keeps its setting.
module pdiv_cfg #(
    parameter int unsigned M_W = 8,
    parameter int unsigned E_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           reload,
    input  logic [M_W-1:0] m_in,
    input  logic [E_W-1:0] e_in,
    output logic [M_W-1:0] m_eff,
    output logic [E_W-1:0] e_eff
);

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [E_W-1:0] e;
        logic           live;
    } cfg_t;

    cfg_t c_d, c_q;
    logic load;

    always_comb begin
        c_d      = c_q;
        load     = !run || !c_q.live || reload;
        c_d.live = run;
        if (load) begin
            c_d.m = m_in;
            c_d.e = e_in;
        end
        // first enabled edge must already see the port values
        m_eff = c_q.live ? c_q.m : m_in;
        e_eff = c_q.live ? c_q.e : e_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/peci_tick_div.sv
module peci_tick_div
    import peci_div_pkg::*;
#(
    parameter int unsigned M_W   = 8,
    parameter int unsigned E_W   = 3,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_en,
    input  logic [M_W-1:0]   msg_tm,
    input  logic [M_W-1:0]   adr_tm,
    input  logic [E_W-1:0]   exp_sel,
    output logic             tick,
    output logic             rate_ok,
    output logic [CNT_W-1:0] tick_count
);

    localparam int unsigned PRE_W = $clog2(PRESCALE);
    localparam int unsigned S2_W  = M_W + $clog2(STEP);
    localparam int unsigned S3_W  = (1 << E_W) - 1;

    typedef struct packed {
        logic             tick;
        logic             ok;
        logic [CNT_W-1:0] cnt;
    } out_t;

    out_t o_d, o_q;

    logic           run;
    logic [M_W-1:0] m_eff;
    logic [E_W-1:0] e_eff;
    logic [S2_W-1:0] lim2;
    logic [S3_W:0]   pow2;
    logic [S3_W-1:0] lim3;
    logic c1, c2, c3;

    assign run = div_en && (msg_tm == adr_tm) && (msg_tm != '0);

    pdiv_cfg #(.M_W(M_W), .E_W(E_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (c3),
        .m_in   (msg_tm),
        .e_in   (exp_sel),
        .m_eff  (m_eff),
        .e_eff  (e_eff)
    );

    always_comb begin
        lim2 = S2_W'(m_eff) * S2_W'(STEP);
        pow2 = (S3_W+1)'(1) << e_eff;
        lim3 = S3_W'(pow2 - 1'b1);
    end

    pdiv_stage #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .adv   (run),
        .lim   (PRE_W'(PRESCALE - 1)),
        .carry (c1)
    );

    pdiv_stage #(.W(S2_W)) u_mid (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .adv   (c1),
        .lim   (lim2),
        .carry (c2)
    );

    pdiv_stage #(.W(S3_W)) u_pow (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .adv   (c2),
        .lim   (lim3),
        .carry (c3)
    );

    always_comb begin
        o_d      = o_q;
        o_d.tick = c3;
        o_d.ok   = run;
        o_d.cnt  = o_q.cnt + CNT_W'(c3);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tick       = o_q.tick;
    assign rate_ok    = o_q.ok;
    assign tick_count = o_q.cnt;

endmodule

// File: rtl/peci_tick_div_chk.sv
module peci_tick_div_chk
    import peci_div_pkg::*;
#(
    parameter int unsigned M_W   = 8,
    parameter int unsigned E_W   = 3,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_en,
    input logic [M_W-1:0]   msg_tm,
    input logic [M_W-1:0]   adr_tm,
    input logic             tick,
    input logic             rate_ok,
    input logic [CNT_W-1:0] tick_count
);

    logic        cfg_ok;
    logic [15:0] gap_q;

    assign cfg_ok = div_en && (msg_tm == adr_tm) && (msg_tm != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '1;
        end else if (tick) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r2_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q >= 16'(MIN_PERIOD - 1)));

    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r4_ok_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |=> rate_ok);

    a_r4_bad_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> !rate_ok);

    a_r5_tick_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(cfg_ok));

    a_r6_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> !tick);

    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (tick_count == $past(tick_count) + 1'b1));

    a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> $stable(tick_count));

endmodule

bind peci_tick_div peci_tick_div_chk #(.M_W(M_W), .E_W(E_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_en     (div_en),
    .msg_tm     (msg_tm),
    .adr_tm     (adr_tm),
    .tick       (tick),
    .rate_ok    (rate_ok),
    .tick_count (tick_count)
);

// File: tb/tb_peci_tick_div.sv
`timescale 1ns/1ps
module tb_peci_tick_div;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          div_en = 1'b0;
    logic [7:0]    msg_tm = '0;
    logic [7:0]    adr_tm = '0;
    logic [2:0]    exp_sel = '0;
    logic          tick;
    logic          rate_ok;
    logic [CW-1:0] tick_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_all = 0;

    always #2 clk = ~clk;

    peci_tick_div #(.M_W(8), .E_W(3), .CNT_W(CW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_en     (div_en),
        .msg_tm     (msg_tm),
        .adr_tm     (adr_tm),
        .exp_sel    (exp_sel),
        .tick       (tick),
        .rate_ok    (rate_ok),
        .tick_count (tick_count)
    );

    function automatic int period(int m, int e);
        return 4 * (4 * m + 1) * (1 << e);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(int m, int a, int e, bit en);
        @(negedge clk);
        msg_tm  = 8'(m);
        adr_tm  = 8'(a);
        exp_sel = 3'(e);
        div_en  = en;
    endtask

    task automatic wait_tick(int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < lim);
    endtask

    task automatic count_ticks(int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
    endtask

    task automatic run_case(int m, int e);
        int n;
        int nn;
        int c0;
        nn = period(m, e);
        setup(m, m, e, 1'b0);
        setup(m, m, e, 1'b1);
        c0 = int'(tick_count);
        wait_tick(nn + 50, n);
        check(n == nn, $sformatf("R2 first tick M=%0d E=%0d", m, e), n, nn);
        @(negedge clk);
        check(!tick, "R3 tick width", int'(tick), 0);
        wait_tick(nn + 50, n);
        check(n + 1 == nn, $sformatf("R2 gap M=%0d E=%0d", m, e), n + 1, nn);
        check(int'(tick_count) == ((c0 + 2) % 16), "R8 count step",
              int'(tick_count), (c0 + 2) % 16);
    endtask

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 180000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<180000", cyc_all);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        int seen;
        int c0;
        void'($urandom(32'd4711));

        // R1 reset state
        repeat (4) @(negedge clk);
        check(!tick && !rate_ok && tick_count == 0, "R1 during reset",
              int'({tick, rate_ok, tick_count}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!tick && !rate_ok && tick_count == 0, "R1 after release",
              int'({tick, rate_ok, tick_count}), 0);

        // R4 valid flag
        setup(3, 3, 0, 1'b1);
        @(negedge clk);
        check(rate_ok == 1'b1, "R4 matched codes", int'(rate_ok), 1);
        setup(3, 4, 0, 1'b1);
        @(negedge clk);
        check(rate_ok == 1'b0, "R4 mismatched codes", int'(rate_ok), 0);
        setup(0, 0, 0, 1'b1);
        @(negedge clk);
        check(rate_ok == 1'b0, "R4 zero code", int'(rate_ok), 0);
        setup(3, 3, 0, 1'b0);
        @(negedge clk);
        check(rate_ok == 1'b0, "R4 disabled", int'(rate_ok), 0);

        // R5 invalid settings give no ticks
        c0 = int'(tick_count);
        setup(5, 6, 0, 1'b1);
        count_ticks(300, seen);
        check(seen == 0, "R5 mismatch ticks", seen, 0);
        check(int'(tick_count) == c0, "R5 mismatch count", int'(tick_count), c0);
        setup(0, 0, 0, 1'b1);
        count_ticks(300, seen);
        check(seen == 0, "R5 zero-code ticks", seen, 0);
        check(int'(tick_count) == c0, "R5 zero-code count", int'(tick_count), c0);

        // R2 / R3 / R8 directed corners
        run_case(1, 0);
        run_case(255, 0);
        run_case(1, 7);
        run_case(255, 2);
        run_case(2, 1);

        // R6 disable mid-period restarts a full period
        setup(1, 1, 1, 1'b0);
        setup(1, 1, 1, 1'b1);
        repeat (25) @(negedge clk);
        div_en = 1'b0;
        count_ticks(10, seen);
        check(seen == 0, "R6 no tick while disabled", seen, 0);
        check(rate_ok == 1'b0, "R6 flag while disabled", int'(rate_ok), 0);
        div_en = 1'b1;
        wait_tick(200, n);
        check(n == period(1, 1), "R6 full period after re-enable", n, period(1, 1));

        // R7 mid-period setting change
        setup(1, 1, 0, 1'b0);
        setup(1, 1, 0, 1'b1);
        repeat (5) @(negedge clk);
        msg_tm  = 8'd2;
        adr_tm  = 8'd2;
        exp_sel = 3'd1;
        wait_tick(200, n);
        check(n == 15, "R7 current period kept", n, 15);
        wait_tick(200, n);
        check(n == period(2, 1), "R7 new period applied", n, period(2, 1));

        // R8 wrap of the tick counter
        setup(1, 1, 0, 1'b0);
        c0 = int'(tick_count);
        setup(1, 1, 0, 1'b1);
        count_ticks(17 * 20, seen);
        check(seen == 17, "R8 tick total", seen, 17);
        check(int'(tick_count) == ((c0 + 17) % 16), "R8 wrap",
              int'(tick_count), (c0 + 17) % 16);

        // random settings
        for (int k = 0; k < 10; k++) begin
            int m;
            int e;
            m = 1 + int'($urandom % 24);
            e = int'($urandom % 4);
            run_case(m, e);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule